// File: doc/BRIEF.md
# Serial-Commanded Triple Half-Bridge Gate Control

This block is the digital core that steers three half-bridges, each made of a high-side switch and a low-side switch, from a 16-bit command word. The word is shifted in serially while chip select is low, sampled on the rising edge of the serial clock and sent most significant bit first. It is copied into a control register when chip select rises. The control register drives six gate-on commands. Each command can also be ANDed with an external PWM pin. A software inhibit bit and an overcurrent shutdown can force the outputs off.

While a word is shifted in, the previous state is shifted out on the serial data output. This state is made of sticky fault flags and an echo of part of the control register. The shift register is exactly one word long, so a bit that enters it leaves it on the data output 16 clocks later. Several devices wired output-to-input under one chip select therefore form a daisy chain. A transfer of n words gives the first word to the device farthest down the chain. Fault sensing is outside this block: per-switch, overtemperature and undervoltage fault flags arrive as plain inputs.

All serial pins are sampled by the system clock through synchronizers. The PWM path from `pwm_in` to `gate_on` is purely combinational.

Top module: `hbridge_spi_ctrl`

## Requirements
- R1: While `spi_cs_n` is low, `spi_mosi` is shifted in on each rising `spi_sck` edge, most significant bit first. The rising edge of `spi_cs_n` commits the shifted word to the control register.
- R2: A word is committed only if the number of rising `spi_sck` edges since `spi_cs_n` fell is a nonzero multiple of 16. In every other case the control register keeps its previous value.
- R3: Control bits 1 to 6 enable gate outputs 0 to 5, in this order: low 1, high 1, low 2, high 2, low 3, high 3. `gate_on[k]` is 1 only when enable bit k+1 is 1.
- R4: When control bit k+7 is 1 (for k from 0 to 5), `gate_on[k]` is additionally ANDed with `pwm_in`, with no register on that path.
- R5: Control bit 15 low (software inhibit) forces all six gates off. The stored control value is unchanged, so writing bit 15 high again restores the earlier outputs.
- R6: `ol_det_en` is the inverse of control bit 13. Writing 0 to bit 13 enables open-load detection.
- R7: When control bit 14 is 1, any gate whose sticky fault flag is set is forced off. When bit 14 is 0, the flags do not affect the gates.
- R8: Fault flags are sticky. A committed word with bit 0 set clears them. A fault that is still asserted at that moment stays set.
- R9: When `spi_cs_n` falls, a status word is loaded and shifted out most significant bit first, and `spi_miso` changes after falling `spi_sck` edges. The status word holds: bit 15 undervoltage, bit 14 overtemperature, bits 13 to 7 a copy of control bits 13 to 7, bits 6 to 1 the per-switch fault flags in gate order, and bit 0 = 0.
- R10: After 16 clocks, `spi_miso` shows the bits received on `spi_mosi` 16 clocks earlier. With two devices chained under one chip select, a 32-bit transfer gives its first 16 bits to the second device and its last 16 bits to the first device.
- R11: `spi_miso_oe` is 0 and `spi_miso` is high-impedance while `spi_cs_n` is high. `spi_miso_oe` is 1 while `spi_cs_n` is low.
- R12: After reset the control register is zero: all gates are off, `ol_det_en` is 1 and `spi_miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, high-impedance when deselected |
| spi_miso_oe | output | 1 | Drive enable for the serial data out |
| pwm_in | input | 1 | External PWM signal for gated outputs |
| flt_sw | input | 6 | Per-switch fault flags, in gate order |
| flt_ot | input | 1 | Overtemperature fault flag |
| flt_uv | input | 1 | Undervoltage fault flag |
| gate_on | output | 6 | Gate commands: low 1, high 1, low 2, high 2, low 3, high 3 |
| ol_det_en | output | 1 | Open-load detection enable |

## Verification
The assertions check the following on every cycle:
- the control register changes only at a commit that coincides with a chip-select rise;
- no gate is on without its enable bit;
- no PWM-gated output is on while `pwm_in` is low;
- inhibit and overcurrent shutdown hold the gates off;
- fault flags only clear at a status reset.

The bench scenarios are what show the rest. They show the bit ordering of the word and of the status stream, that transfers with a partial bit count are rejected, and that outputs come back after inhibit. They also show that a fault still active during a clear stays set, and that data passes correctly through a two-device daisy chain.

// File: rtl/hb_drv_pkg.sv
package hb_drv_pkg;
  localparam int WORD_W  = 16;
  localparam int NUM_HB  = 3;
  localparam int NUM_SW  = 2 * NUM_HB;
  localparam int CNT_W   = $clog2(WORD_W);
  localparam int FLG_W   = NUM_SW + 2;
  // control word field positions
  localparam int SRR_POS = 0;
  localparam int EN_POS  = SRR_POS + 1;
  localparam int PWM_POS = EN_POS + NUM_SW;
  localparam int OLD_POS = PWM_POS + NUM_SW;
  localparam int OCS_POS = OLD_POS + 1;
  localparam int SI_POS  = OCS_POS + 1;
  // status word field positions
  localparam int OT_POS  = WORD_W - 2;
  localparam int UV_POS  = WORD_W - 1;
  localparam int ECHO_LO = PWM_POS;
  localparam int ECHO_HI = OLD_POS;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/hb_spi_shift.sv
module hb_spi_shift import hb_drv_pkg::*; #(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sck,
  input  logic         mosi,
  input  logic [W-1:0] status,
  output logic [W-1:0] word,
  output logic         commit,
  output logic         dout,
  output logic         dout_oe
);
  logic          cs_d_q, sck_d_q;
  logic          cs_fall, cs_rise, sck_rise, sck_fall;
  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          any_q, any_d;
  logic          dout_q, dout_d;
  logic          sh_en, dout_en;

  assign cs_fall  = cs_d_q & ~cs_n;
  assign cs_rise  = ~cs_d_q & cs_n;
  assign sck_rise = ~sck_d_q & sck & ~cs_n;
  assign sck_fall = sck_d_q & ~sck & ~cs_n;

  assign sh_en   = cs_fall | sck_rise;
  assign dout_en = cs_fall | sck_fall;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    any_d  = any_q;
    dout_d = dout_q;
    if (cs_fall) begin
      sh_d   = status;
      cnt_d  = '0;
      any_d  = 1'b0;
      dout_d = status[W-1];
    end else if (sck_rise) begin
      sh_d  = {sh_q[W-2:0], mosi};
      cnt_d = cnt_q + 1'b1;
      any_d = 1'b1;
    end else if (sck_fall) begin
      dout_d = sh_q[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
      any_q   <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      cs_d_q  <= cs_n;
      sck_d_q <= sck;
      if (sh_en) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
        any_q <= any_d;
      end
      if (dout_en) dout_q <= dout_d;
    end
  end

  assign word    = sh_q;
  assign commit  = cs_rise & any_q & (cnt_q == '0);
  assign dout    = dout_q;
  assign dout_oe = ~cs_n;
endmodule

// File: rtl/hb_ctrl_reg.sv
module hb_ctrl_reg import hb_drv_pkg::*; #(
  parameter int W  = WORD_W,
  parameter int NS = NUM_SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [W-1:0]  word,
  input  logic [NS-1:0] flt_sw,
  input  logic          flt_ot,
  input  logic          flt_uv,
  output logic [W-1:0]  ctrl,
  output logic [NS-1:0] sw_flags,
  output logic          stat_clr,
  output logic [W-1:0]  status
);
  localparam int FW = NS + 2;

  logic [W-1:0]  ctrl_q, ctrl_d;
  logic [FW-1:0] flg_q, flg_d, flg_live;

  assign stat_clr = commit & word[SRR_POS];
  assign flg_live = {flt_uv, flt_ot, flt_sw};

  always_comb begin
    ctrl_d = commit ? word : ctrl_q;
    flg_d  = (stat_clr ? '0 : flg_q) | flg_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flg_q  <= '0;
    end else begin
      if (commit) ctrl_q <= ctrl_d;
      flg_q <= flg_d;
    end
  end

  always_comb begin
    status                    = '0;
    status[EN_POS +: NS]      = flg_q[NS-1:0];
    status[ECHO_HI:ECHO_LO]   = ctrl_q[ECHO_HI:ECHO_LO];
    status[OT_POS]            = flg_q[NS];
    status[UV_POS]            = flg_q[NS+1];
  end

  assign ctrl     = ctrl_q;
  assign sw_flags = flg_q[NS-1:0];
endmodule

// File: rtl/hb_gate.sv
module hb_gate import hb_drv_pkg::*; #(
  parameter int NS = NUM_SW
) (
  input  logic [NS-1:0] en,
  input  logic [NS-1:0] pwm_sel,
  input  logic          run,
  input  logic          ocs_en,
  input  logic [NS-1:0] sw_flags,
  input  logic          pwm,
  output logic [NS-1:0] gate
);
  for (genvar k = 0; k < NS; k++) begin : g_sw
    logic pwm_ok, trip;
    assign pwm_ok  = ~pwm_sel[k] | pwm;
    assign trip    = ocs_en & sw_flags[k];
    assign gate[k] = en[k] & pwm_ok & run & ~trip;
  end
endmodule

// File: rtl/hbridge_spi_ctrl.sv
module hbridge_spi_ctrl import hb_drv_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              pwm_in,
  input  logic [NUM_SW-1:0] flt_sw,
  input  logic              flt_ot,
  input  logic              flt_uv,
  output logic [NUM_SW-1:0] gate_on,
  output logic              ol_det_en
);
  logic              rst_ns;
  logic [2:0]        spi_s;
  logic              cs_s, sck_s, mosi_s;
  logic [FLG_W-1:0]  flt_s;
  logic [WORD_W-1:0] word, ctrl_q, status;
  logic [NUM_SW-1:0] sw_flt_q;
  logic              commit, stat_clr, dout;

  hb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns));

  hb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_spi_sync (
    .clk(clk), .rst_n(rst_ns), .d({spi_mosi, spi_sck, spi_cs_n}), .q(spi_s));

  assign cs_s   = spi_s[0];
  assign sck_s  = spi_s[1];
  assign mosi_s = spi_s[2];

  hb_sync #(.W(FLG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_flt_sync (
    .clk(clk), .rst_n(rst_ns), .d({flt_uv, flt_ot, flt_sw}), .q(flt_s));

  hb_spi_shift #(.W(WORD_W), .CW(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_ns), .cs_n(cs_s), .sck(sck_s), .mosi(mosi_s),
    .status(status), .word(word), .commit(commit), .dout(dout),
    .dout_oe(spi_miso_oe));

  hb_ctrl_reg #(.W(WORD_W), .NS(NUM_SW)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .commit(commit), .word(word),
    .flt_sw(flt_s[NUM_SW-1:0]), .flt_ot(flt_s[NUM_SW]), .flt_uv(flt_s[NUM_SW+1]),
    .ctrl(ctrl_q), .sw_flags(sw_flt_q), .stat_clr(stat_clr), .status(status));

  hb_gate #(.NS(NUM_SW)) u_gate (
    .en(ctrl_q[EN_POS +: NUM_SW]), .pwm_sel(ctrl_q[PWM_POS +: NUM_SW]),
    .run(ctrl_q[SI_POS]), .ocs_en(ctrl_q[OCS_POS]), .sw_flags(sw_flt_q),
    .pwm(pwm_in), .gate(gate_on));

  assign spi_miso  = spi_miso_oe ? dout : 1'bz;
  assign ol_det_en = ~ctrl_q[OLD_POS];
endmodule

// File: rtl/hbridge_spi_chk.sv
module hbridge_spi_chk import hb_drv_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic [WORD_W-1:0] ctrl_q,
  input logic [NUM_SW-1:0] sw_flt_q,
  input logic              commit,
  input logic              stat_clr,
  input logic              pwm_in,
  input logic [NUM_SW-1:0] gate_on
);
  AST_COMMIT_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cs_s && !$past(cs_s)));                                       // R1
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctrl_q));                                             // R2
  AST_EN_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on & ~ctrl_q[EN_POS +: NUM_SW]) == '0);                             // R3
  AST_PWM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |-> ((gate_on & ctrl_q[PWM_POS +: NUM_SW]) == '0));               // R4
  AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[SI_POS] |-> (gate_on == '0));                                     // R5
  AST_OCS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[OCS_POS] |-> ((gate_on & sw_flt_q) == '0));                        // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((sw_flt_q & $past(sw_flt_q)) == $past(sw_flt_q)));         // R8
endmodule

bind hbridge_spi_ctrl hbridge_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .ctrl_q(ctrl_q), .sw_flt_q(sw_flt_q),
  .commit(commit), .stat_clr(stat_clr), .pwm_in(pwm_in), .gate_on(gate_on));

// File: tb/sim_hbridge_spi_ctrl.sv
// One time unit is 1 ns; the clock period of 20 units gives 50 MHz.
module sim_hbridge_spi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, pwm = 1'b0;
  logic [5:0] flt_sw = '0;
  logic       flt_ot = 1'b0, flt_uv = 1'b0;
  wire        miso0, miso1, oe0, oe1, ol0, ol1;
  wire  [5:0] gate0, gate1;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  hbridge_spi_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso0), .spi_miso_oe(oe0), .pwm_in(pwm), .flt_sw(flt_sw),
    .flt_ot(flt_ot), .flt_uv(flt_uv), .gate_on(gate0), .ol_det_en(ol0));

  hbridge_spi_ctrl u1 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(miso0),
    .spi_miso(miso1), .spi_miso_oe(oe1), .pwm_in(pwm), .flt_sw(6'b0),
    .flt_ot(1'b0), .flt_uv(1'b0), .gate_on(gate1), .ol_det_en(ol1));

  typedef struct packed {
    logic [15:0] word;
    logic        pwm;
    logic        ol;
    logic [5:0]  gate;
  } vec_t;

  // control word, PWM level, expected ol_det_en, expected gate_on
  localparam vec_t VEC [9] = '{
    '{16'h8002, 1'b0, 1'b1, 6'h01},
    '{16'h807E, 1'b0, 1'b1, 6'h3F},
    '{16'h80FE, 1'b0, 1'b1, 6'h3E},
    '{16'h80FE, 1'b1, 1'b1, 6'h3F},
    '{16'h007E, 1'b0, 1'b1, 6'h00},
    '{16'h9FFE, 1'b0, 1'b1, 6'h00},
    '{16'h9FFE, 1'b1, 1'b1, 6'h3F},
    '{16'h8054, 1'b0, 1'b1, 6'h2A},
    '{16'hA02A, 1'b0, 1'b0, 6'h15}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic xfer(input logic [31:0] data, input int nbits,
                      output logic [31:0] rx0, output logic [31:0] rx1);
    rx0 = '0;
    rx1 = '0;
    cs_n = 1'b0;
    tick(10);
    chk("R11 miso enabled while selected", {31'b0, oe0}, 32'd1);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = data[i];
      rx0  = {rx0[30:0], miso0};
      rx1  = {rx1[30:0], miso1};
      sck  = 1'b1;
      tick(10);
      sck  = 1'b0;
      tick(10);
    end
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic send(input logic [15:0] w, output logic [15:0] st);
    logic [31:0] r0, r1;
    xfer({16'h0, w}, 16, r0, r1);
    st = r0[15:0];
  endtask

  initial begin
    logic [15:0] st;
    logic [31:0] r0, r1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R12 reset state
    chk("R12 gates off after reset", {26'b0, gate0}, 32'h0);
    chk("R12 open-load enabled after reset", {31'b0, ol0}, 32'd1);
    chk("R12 R11 miso disabled after reset", {31'b0, oe0}, 32'd0);

    // table walk: R1 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      send(VEC[i].word, st);
      pwm = VEC[i].pwm;
      tick(1);
      chk($sformatf("R1 R3 R4 R5 gates, vector %0d", i), {26'b0, gate0}, {26'b0, VEC[i].gate});
      chk($sformatf("R6 open-load enable, vector %0d", i), {31'b0, ol0}, {31'b0, VEC[i].ol});
      pwm = 1'b0;
    end

    // R2 partial transfers are rejected
    send(16'h807E, st);
    chk("R2 baseline", {26'b0, gate0}, 32'h3F);
    xfer(32'h0, 8, r0, r1);
    chk("R2 8-bit transfer ignored", {26'b0, gate0}, 32'h3F);
    xfer(32'h0, 0, r0, r1);
    chk("R2 empty select ignored", {26'b0, gate0}, 32'h3F);
    xfer(32'h0, 17, r0, r1);
    chk("R2 17-bit transfer ignored", {26'b0, gate0}, 32'h3F);
    chk("R11 miso disabled when deselected", {31'b0, oe0}, 32'd0);

    // R5 inhibit keeps the register and restores
    send(16'h007E, st);
    chk("R5 inhibit forces off", {26'b0, gate0}, 32'h0);
    send(16'h807E, st);
    chk("R5 release restores", {26'b0, gate0}, 32'h3F);

    // R9 echo of control bits 13..7
    send(16'h9FFE, st);
    send(16'h807E, st);
    chk("R9 status echo", {16'b0, st}, 32'h1F80);

    // R7 R8 overcurrent shutdown and sticky flags
    send(16'hC07E, st);
    flt_sw = 6'b000001;
    tick(10);
    flt_sw = 6'b0;
    tick(5);
    chk("R7 faulted switch forced off", {26'b0, gate0}, 32'h3E);
    send(16'h807E, st);
    chk("R7 no shutdown when disabled", {26'b0, gate0}, 32'h3F);
    chk("R8 R9 sticky flag in status", {16'b0, st}, 32'h0002);
    send(16'hC07E, st);
    chk("R8 flag still set", {26'b0, gate0}, 32'h3E);
    send(16'hC07F, st);
    chk("R8 status reset clears", {26'b0, gate0}, 32'h3F);
    send(16'hC07E, st);
    chk("R8 status after clear", {16'b0, st}, 32'h0000);

    flt_ot = 1'b1;
    flt_uv = 1'b1;
    tick(10);
    flt_ot = 1'b0;
    flt_uv = 1'b0;
    send(16'h807E, st);
    chk("R9 temperature and voltage flags", {16'b0, st}, 32'hC000);

    flt_sw = 6'b100000;
    tick(10);
    send(16'h807F, st);
    send(16'h807E, st);
    chk("R8 live fault survives clear", {16'b0, st}, 32'h0040);
    flt_sw = 6'b0;
    tick(5);
    send(16'h9FFF, st);

    // R10 two-device chain
    xfer({16'h8054, 16'h802A}, 32, r0, r1);
    chk("R10 last word to first device", {26'b0, gate0}, 32'h15);
    chk("R10 first word to second device", {26'b0, gate1}, 32'h2A);
    chk("R10 first device status passed through", {16'b0, r1[15:0]}, 32'h1F80);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end
endmodule